// File: doc/BRIEF.md
# Processor-Driven BIST Register Bridge

This block lets a small 8-bit microcontroller run a memory self-test one step at a time over its narrow I/O bus. The test-pattern sequence lives in processor software. The bridge holds the pattern signals for the memories under test and turns qualified processor strobes into single BIST clock enables. It also compares the responses of two memories and returns the accumulated pass/fail bits a byte at a time.

Each access puts one byte on the bus and raises one select line together with either the write strobe or the read strobe for a single clock. Two staging registers, loaded a byte at a time, drive the address, the data, the write enable and the output enable for the memories. A write on the step line produces a one-cycle clock enable. During that cycle, any bit where the two response words differ is latched into a sticky fail register. That register doubles as a scan chain: each qualified read on the scan line returns its lowest byte and shifts the remainder down.

Top module: `bist_bridge`

## Requirements
- R1: After reset, every staging output, `bist_ce_o` and `rd_data_o` are zero, and all fail bits are clear.
- R2: A write with select line 1 alone loads the bus byte into the address output, visible from the clock after the access.
- R3: A write with select line 2 alone loads the bus byte into the second staging register. Bits [5:0] drive `tpg_data_o`, bit 6 drives `tpg_we_o` and bit 7 drives `tpg_oe_o`.
- R4: A write with select line 3 alone raises `bist_ce_o` for exactly the one clock after the access.
- R5: In a clock where `bist_ce_o` is high, every bit position where `resp_a_i` and `resp_b_i` differ sets its fail bit, which stays set. Differences in other clocks have no effect.
- R6: A write with select line 0 alone clears every fail bit and leaves the staging registers unchanged.
- R7: A read with select line 4 alone places fail bits [7:0] on `rd_data_o` from the next clock and shifts the chain down by 8 with zero fill. `rd_data_o` holds its value until the next such read.
- R8: An access with no select line, with more than one select line, or with both strobes high has no effect.
- R9: Select lines act only with their own strobe. Select lines 0 to 3 ignore the read strobe, select line 4 ignores the write strobe, and no select line acts without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_i | input | 8 | Processor data bus |
| wr_stb_i | input | 1 | Write strobe |
| rd_stb_i | input | 1 | Read strobe |
| sel_i | input | 16 | One-hot function select lines |
| resp_a_i | input | 16 | Response word of first memory |
| resp_b_i | input | 16 | Response word of second memory |
| tpg_addr_o | output | 8 | Staged memory address |
| tpg_data_o | output | 6 | Staged memory write data |
| tpg_we_o | output | 1 | Staged memory write enable |
| tpg_oe_o | output | 1 | Staged memory output enable |
| bist_ce_o | output | 1 | One-cycle BIST clock enable |
| rd_data_o | output | 8 | Readback byte of fail bits |

## Verification
The bench holds a response mismatch on the inputs while no step is in flight. A design that samples outside the enable cycle would report a false fail bit. It issues writes with two select lines, with both strobes, and with the wrong strobe for a line. A decoder that only checks one bit of the select bus would then corrupt staging registers, fire a step or shift the chain. It reads the chain out across byte boundaries until it runs empty, which exposes a wrong shift distance or missing zero fill. It clears the fail bits after a capture and confirms that the staging registers survive, which catches a clear that is wired to the wrong state.

// File: rtl/bist_bridge_pkg.sv
package bist_bridge_pkg;
  localparam int BUS_W = 8;
  localparam int SEL_N = 16;

  // select line numbers; fixed by software convention
  localparam int SEL_CLR  = 0;
  localparam int SEL_STG1 = 1;
  localparam int SEL_STG2 = 2;
  localparam int SEL_STEP = 3;
  localparam int SEL_SCAN = 4;

  typedef struct packed {
    logic clr;
    logic ld1;
    logic ld2;
    logic step;
    logic scan;
  } cmd_t;
endpackage

// File: rtl/bist_bridge_decode.sv
module bist_bridge_decode
  import bist_bridge_pkg::*;
#(
  parameter int SEL_W = SEL_N
) (
  input  logic             wr_stb_i,
  input  logic             rd_stb_i,
  input  logic [SEL_W-1:0] sel_i,
  output cmd_t             cmd_o
);
  logic one_sel, wr_q, rd_q;

  always_comb begin
    one_sel = $onehot(sel_i);
    wr_q    = wr_stb_i & ~rd_stb_i & one_sel;
    rd_q    = rd_stb_i & ~wr_stb_i & one_sel;
    cmd_o.clr  = wr_q & sel_i[SEL_CLR];
    cmd_o.ld1  = wr_q & sel_i[SEL_STG1];
    cmd_o.ld2  = wr_q & sel_i[SEL_STG2];
    cmd_o.step = wr_q & sel_i[SEL_STEP];
    cmd_o.scan = rd_q & sel_i[SEL_SCAN];
  end
endmodule

// File: rtl/bist_bridge_stage.sv
module bist_bridge_stage #(
  parameter int BYTE_W = 8,
  parameter int NREG   = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NREG-1:0]        ld_i,
  input  logic [BYTE_W-1:0]      bus_i,
  output logic [NREG*BYTE_W-1:0] q_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [BYTE_W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    r_q <= '0;
      else if (ld_i[g]) r_q <= bus_i;
    end
    assign q_o[g*BYTE_W +: BYTE_W] = r_q;
  end
endmodule

// File: rtl/bist_bridge_ora.sv
module bist_bridge_ora #(
  parameter int RESP_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic              scan_i,
  input  logic [RESP_W-1:0] resp_a_i,
  input  logic [RESP_W-1:0] resp_b_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  localparam int NBYTE   = (RESP_W + BYTE_W - 1) / BYTE_W;
  localparam int CHAIN_W = NBYTE * BYTE_W;

  logic [CHAIN_W-1:0] chain_q, diff, hit;
  logic [BYTE_W-1:0]  rd_q;

  always_comb begin
    diff = '0;
    diff[RESP_W-1:0] = resp_a_i ^ resp_b_i;
    hit = cap_i ? diff : '0;
  end

  // fail bits double as the scan chain, low byte first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      rd_q    <= '0;
    end else if (clr_i) begin
      chain_q <= '0;
    end else if (scan_i) begin
      rd_q    <= chain_q[BYTE_W-1:0];
      chain_q <= (chain_q >> BYTE_W) | hit;
    end else begin
      chain_q <= chain_q | hit;
    end
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/bist_bridge.sv
module bist_bridge
  import bist_bridge_pkg::*;
#(
  parameter int RESP_W = 16,
  parameter int DATA_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        bus_i,
  input  logic              wr_stb_i,
  input  logic              rd_stb_i,
  input  logic [15:0]       sel_i,
  input  logic [RESP_W-1:0] resp_a_i,
  input  logic [RESP_W-1:0] resp_b_i,
  output logic [7:0]        tpg_addr_o,
  output logic [DATA_W-1:0] tpg_data_o,
  output logic              tpg_we_o,
  output logic              tpg_oe_o,
  output logic              bist_ce_o,
  output logic [7:0]        rd_data_o
);
  localparam int NREG   = 2;
  localparam int WE_BIT = BUS_W + DATA_W;
  localparam int OE_BIT = WE_BIT + 1;

  cmd_t                   cmd;
  logic [NREG*BUS_W-1:0]  stg;
  logic                   ce_q;
  logic [BUS_W*NREG-1:0]  stg_unused;

  bist_bridge_decode #(.SEL_W(SEL_N)) u_dec (
    .wr_stb_i (wr_stb_i),
    .rd_stb_i (rd_stb_i),
    .sel_i    (sel_i),
    .cmd_o    (cmd)
  );

  bist_bridge_stage #(.BYTE_W(BUS_W), .NREG(NREG)) u_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   ({cmd.ld2, cmd.ld1}),
    .bus_i  (bus_i),
    .q_o    (stg)
  );

  // step strobe becomes a single enable pulse on the following clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ce_q <= 1'b0;
    else         ce_q <= cmd.step;
  end

  bist_bridge_ora #(.RESP_W(RESP_W), .BYTE_W(BUS_W)) u_ora (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (cmd.clr),
    .cap_i     (ce_q),
    .scan_i    (cmd.scan),
    .resp_a_i  (resp_a_i),
    .resp_b_i  (resp_b_i),
    .rd_data_o (rd_data_o)
  );

  assign stg_unused = stg;
  assign tpg_addr_o = stg[BUS_W-1:0];
  assign tpg_data_o = stg[BUS_W +: DATA_W];
  assign tpg_we_o   = stg[WE_BIT];
  assign tpg_oe_o   = stg[OE_BIT];
  assign bist_ce_o  = ce_q;
endmodule

// File: rtl/bist_bridge_chk.sv
module bist_bridge_chk #(
  parameter int DATA_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_stb_i,
  input logic              rd_stb_i,
  input logic [15:0]       sel_i,
  input logic [7:0]        tpg_addr_o,
  input logic [DATA_W-1:0] tpg_data_o,
  input logic              tpg_we_o,
  input logic              tpg_oe_o,
  input logic              bist_ce_o,
  input logic [7:0]        rd_data_o
);
  a_r4_ce_after_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && !rd_stb_i && sel_i == 16'h0008) |=> bist_ce_o);

  a_r4_ce_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bist_ce_o |-> $past(wr_stb_i && !rd_stb_i && sel_i == 16'h0008));

  a_r2_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_stb_i && !rd_stb_i && sel_i == 16'h0002) |=> $stable(tpg_addr_o));

  a_r3_stage2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_stb_i && !rd_stb_i && sel_i == 16'h0004)
      |=> $stable({tpg_oe_o, tpg_we_o, tpg_data_o}));

  a_r7_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_stb_i && !wr_stb_i && sel_i == 16'h0010) |=> $stable(rd_data_o));

  a_r8_multi_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(sel_i) > 1) |=> !bist_ce_o);
endmodule

bind bist_bridge bist_bridge_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/bist_bridge_bench.sv
module bist_bridge_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  bus_i = '0;
  logic        wr_stb_i = 1'b0;
  logic        rd_stb_i = 1'b0;
  logic [15:0] sel_i = '0;
  logic [15:0] resp_a_i = '0;
  logic [15:0] resp_b_i = '0;
  logic [7:0]  tpg_addr_o;
  logic [5:0]  tpg_data_o;
  logic        tpg_we_o, tpg_oe_o, bist_ce_o;
  logic [7:0]  rd_data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  bist_bridge u_bist_bridge (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [15:0] s, input logic w, input logic r, input logic [7:0] b);
    sel_i = s; wr_stb_i = w; rd_stb_i = r; bus_i = b;
    @(negedge clk_i);
    sel_i = '0; wr_stb_i = 1'b0; rd_stb_i = 1'b0; bus_i = '0;
  endtask

  task automatic step(input string req);
    acc(16'h0008, 1'b1, 1'b0, 8'h00);
    check(req, {31'd0, bist_ce_o}, 32'd1);
    @(negedge clk_i);
    check(req, {31'd0, bist_ce_o}, 32'd0);
  endtask

  task automatic read_byte(input string req, input logic [7:0] exp);
    acc(16'h0010, 1'b0, 1'b1, 8'h00);
    check(req, {24'd0, rd_data_o}, {24'd0, exp});
  endtask

  // {sel, wr, rd, bus, exp_addr, exp_stage2}
  localparam int NV = 9;
  localparam logic [41:0] VEC [NV] = '{
    {16'h0002, 1'b1, 1'b0, 8'hA5, 8'hA5, 8'h00},
    {16'h0004, 1'b1, 1'b0, 8'hC3, 8'hA5, 8'hC3},
    {16'h0006, 1'b1, 1'b0, 8'hFF, 8'hA5, 8'hC3},
    {16'h0000, 1'b1, 1'b0, 8'h11, 8'hA5, 8'hC3},
    {16'h0002, 1'b0, 1'b1, 8'h22, 8'hA5, 8'hC3},
    {16'h0002, 1'b1, 1'b1, 8'h33, 8'hA5, 8'hC3},
    {16'h0002, 1'b0, 1'b0, 8'h44, 8'hA5, 8'hC3},
    {16'h0004, 1'b1, 1'b0, 8'h5A, 8'hA5, 8'h5A},
    {16'h0002, 1'b1, 1'b0, 8'h3C, 8'h3C, 8'h5A}
  };

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 addr", {24'd0, tpg_addr_o}, 32'd0);
    check("R1 stage2", {24'd0, tpg_oe_o, tpg_we_o, tpg_data_o}, 32'd0);
    check("R1 ce", {31'd0, bist_ce_o}, 32'd0);
    check("R1 rd", {24'd0, rd_data_o}, 32'd0);

    // R2 R3 R8 R9 staging vectors
    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][41:26], VEC[i][25], VEC[i][24], VEC[i][23:16]);
      check("R2 addr", {24'd0, tpg_addr_o}, {24'd0, VEC[i][15:8]});
      check("R3 stage2", {24'd0, tpg_oe_o, tpg_we_o, tpg_data_o}, {24'd0, VEC[i][7:0]});
    end
    check("R3 we bit6", {31'd0, tpg_we_o}, 32'd1);
    check("R3 oe bit7", {31'd0, tpg_oe_o}, 32'd0);

    // R5 mismatch outside a step is ignored
    resp_a_i = 16'h0100;
    repeat (3) @(negedge clk_i);
    resp_a_i = 16'h0000;
    // R4 R5 captures
    resp_a_i = 16'h0081;
    step("R4 pulse a");
    resp_a_i = 16'h0000;
    resp_b_i = 16'h8000;
    step("R4 pulse b");
    resp_b_i = 16'h0000;
    // R7 readout with shift and zero fill
    read_byte("R7 byte0", 8'h81);
    read_byte("R7 byte1", 8'h80);
    read_byte("R7 empty", 8'h00);
    repeat (2) @(negedge clk_i);
    check("R7 hold", {24'd0, rd_data_o}, 32'd0);

    // R9 write strobe on scan line does not shift
    resp_a_i = 16'h0003;
    step("R4 pulse c");
    resp_a_i = 16'h0000;
    acc(16'h0010, 1'b1, 1'b0, 8'h00);
    check("R9 wr on scan", {24'd0, rd_data_o}, 32'd0);
    read_byte("R9 chain intact", 8'h03);
    // R9 read strobe on step line does not step
    acc(16'h0008, 1'b0, 1'b1, 8'h00);
    check("R9 rd on step", {31'd0, bist_ce_o}, 32'd0);

    // R6 clear
    resp_a_i = 16'h0F0F;
    step("R4 pulse d");
    resp_a_i = 16'h0000;
    acc(16'h0001, 1'b1, 1'b0, 8'h77);
    check("R6 addr kept", {24'd0, tpg_addr_o}, 32'h3C);
    check("R6 stage2 kept", {24'd0, tpg_oe_o, tpg_we_o, tpg_data_o}, 32'h5A);
    read_byte("R6 cleared lo", 8'h00);
    read_byte("R6 cleared hi", 8'h00);

    // R8 multi-select read and multi-select step ignored
    resp_a_i = 16'h00FF;
    step("R4 pulse e");
    resp_a_i = 16'h0000;
    acc(16'h0018, 1'b0, 1'b1, 8'h00);
    check("R8 multi read", {24'd0, rd_data_o}, 32'd0);
    acc(16'h0018, 1'b1, 1'b0, 8'h00);
    check("R8 multi step", {31'd0, bist_ce_o}, 32'd0);
    read_byte("R8 chain intact", 8'hFF);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule